// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

The block routes a wide set of GPIO pad inputs onto eight interrupt channels that feed a downstream interrupt controller. Each channel picks one pad through a programmable selector, optionally filters glitches, and conditions the signal in a trigger stage. The downstream controller accepts only active-high levels or rising edges. The trigger stage therefore inverts low-level and falling-edge sources, and turns edges into one-clock pulses.

Pads first pass through a two-flop synchroniser. Software programs the block through a small 32-bit register port. Every write carries a bit mask, so a write changes only the fields of the channel it targets. Reads return the register at the given offset combinationally.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all registers read zero, and every channel follows pad 0 as an active-high level with no filter.
- R2: Register offsets are fixed. The trigger register is at 0x0: bit n is edge mode, bit 8+n is both-edges and bit 16+n is low/falling polarity for channel n, and bits 31:24 read zero. Pad select for channels 0-3 is at 0x4 and for channels 4-7 at 0x8, each an 8-bit field at shift (n mod 4)*8. The filter register is at 0xC, a 4-bit field at shift n*4. Any other offset reads zero.
- R3: A write changes only the register bits whose mask bit is 1; all other bits keep their value.
- R4: In level mode without inversion, a channel output equals its selected pad, two clocks after the pad changes.
- R5: With the polarity-low bit set in level mode, the output is the inverse of the selected pad.
- R6: In edge mode, a rising pad edge gives a single one-clock high pulse, and a falling edge gives none.
- R7: In edge mode with polarity-low, a falling pad edge gives a single one-clock pulse, and a rising edge gives none.
- R8: With both-edges set, every pad change gives a one-clock pulse, whatever the edge and polarity bits hold.
- R9: With filter value F > 0, a pad change reaches the output only after it has been stable for 4*F clocks; shorter glitches are dropped.
- R10: A pad select at or above the implemented pad count reads as a constant 0 input, so the output is 0 in level mode and 1 in level mode with polarity-low.
- R11: Each channel responds only to its own selected pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write enable |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 8 | Conditioned interrupt lines to the downstream controller |

## Verification
The bench builds the block with NUM_PADS set to 12 instead of the default 256. An 8-bit selector can then hold values past the last pad, which brings the constant-zero input path within reach. The default pad count would leave that path unreachable. The smaller count also keeps the pad vector short enough to drive pads one by one in directed tests. The filter is checked at F=1, which gives a four-clock window, both with a glitch shorter than the window and with a step held longer.

// File: rtl/gim_pkg.sv
// Package: shared constants and the per-channel configuration type.
// Assumes exactly eight channels; the register layout depends on that count.
package gim_pkg;
    localparam int NUM_CH  = 8;
    localparam int SEL_W   = 8;
    localparam int FILT_W  = 4;
    localparam int FILT_SH = 2;   // filter window = value << FILT_SH clocks

    localparam logic [3:0] OFS_TRIG  = 4'h0;
    localparam logic [3:0] OFS_SELLO = 4'h4;
    localparam logic [3:0] OFS_SELHI = 4'h8;
    localparam logic [3:0] OFS_FILT  = 4'hC;

    typedef struct packed {
        logic              edge_md;
        logic              both_md;
        logic              pol_low;
        logic [SEL_W-1:0]  sel;
        logic [FILT_W-1:0] filt;
    } ch_cfg_t;
endpackage

// File: rtl/gim_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gim_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    // Shift pad values through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/gim_regs.sv
// Module: configuration registers with masked writes and combinational reads.
// Assumes byte offsets 0x0/0x4/0x8/0xC; all other offsets read zero.
module gim_regs
    import gim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [3:0]           addr_i,
    input  logic [31:0]          wdata_i,
    input  logic [31:0]          wmask_i,
    output logic [31:0]          rdata_o,
    output ch_cfg_t [NUM_CH-1:0] cfg_o
);
    localparam int TRIG_W = 3 * NUM_CH;

    logic [TRIG_W-1:0] trig_q;
    logic [31:0]       sello_q, selhi_q, filt_q;

    // Apply masked writes to the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= '0;
            sello_q <= '0;
            selhi_q <= '0;
            filt_q  <= '0;
        end else if (we_i) begin
            unique case (addr_i)
                OFS_TRIG:  trig_q  <= (trig_q & ~wmask_i[TRIG_W-1:0])
                                      | (wdata_i[TRIG_W-1:0] & wmask_i[TRIG_W-1:0]);
                OFS_SELLO: sello_q <= (sello_q & ~wmask_i) | (wdata_i & wmask_i);
                OFS_SELHI: selhi_q <= (selhi_q & ~wmask_i) | (wdata_i & wmask_i);
                OFS_FILT:  filt_q  <= (filt_q & ~wmask_i) | (wdata_i & wmask_i);
                default: ;
            endcase
        end
    end

    // Return the addressed register.
    always_comb begin
        unique case (addr_i)
            OFS_TRIG:  rdata_o = {{(32-TRIG_W){1'b0}}, trig_q};
            OFS_SELLO: rdata_o = sello_q;
            OFS_SELHI: rdata_o = selhi_q;
            OFS_FILT:  rdata_o = filt_q;
            default:   rdata_o = '0;
        endcase
    end

    // Unpack register fields into per-channel configuration.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_unpack
        localparam int SSH = (n % 4) * SEL_W;
        assign cfg_o[n].edge_md = trig_q[n];
        assign cfg_o[n].both_md = trig_q[NUM_CH + n];
        assign cfg_o[n].pol_low = trig_q[2*NUM_CH + n];
        assign cfg_o[n].sel     = (n < 4) ? sello_q[SSH +: SEL_W] : selhi_q[SSH +: SEL_W];
        assign cfg_o[n].filt    = filt_q[n*FILT_W +: FILT_W];
    end

    // R3: bits outside the write mask keep their value.
    a_r3_rmw_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_SELLO) |=> ((sello_q ^ $past(sello_q)) & ~$past(wmask_i)) == 32'd0);
    a_r3_rmw_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_TRIG) |=> ((trig_q ^ $past(trig_q)) & ~$past(wmask_i[TRIG_W-1:0])) == '0);
    // R3: no write strobe, no change.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(trig_q) && $stable(sello_q) && $stable(selhi_q) && $stable(filt_q)));
endmodule

// File: rtl/gim_channel.sv
// Module: one interrupt channel - pad select, glitch filter, trigger stage.
// Assumes pads_i is already synchronised; the output is active-high level or one-clock pulse.
module gim_channel
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads_i,
    input  ch_cfg_t             cfg_i,
    output logic                irq_o
);
    localparam int CNT_W = FILT_W + FILT_SH;

    logic             raw, inv, x, flt, fval, prev;
    logic [CNT_W-1:0] cnt, lim;
    logic             sel_oor;

    // Pick the selected pad; an unimplemented index yields 0.
    always_comb begin
        raw = 1'b0;
        for (int i = 0; i < NUM_PADS; i++)
            if (cfg_i.sel == SEL_W'(i)) raw = pads_i[i];
    end

    assign inv = cfg_i.pol_low & ~cfg_i.both_md;
    assign x   = raw ^ inv;
    assign lim = (CNT_W'(cfg_i.filt) << FILT_SH) - CNT_W'(1);
    assign flt = (cfg_i.filt == '0) ? x : fval;

    // Track the filtered value, the stability count and the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval <= 1'b0;
            cnt  <= '0;
            prev <= 1'b0;
        end else begin
            prev <= flt;
            if (cfg_i.filt == '0) begin
                fval <= x;
                cnt  <= '0;
            end else if (x == fval) begin
                cnt <= '0;
            end else if (cnt == lim) begin
                fval <= x;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Form the downstream line: level, single-edge pulse or any-edge pulse.
    always_comb begin
        if (cfg_i.both_md)      irq_o = flt ^ prev;
        else if (cfg_i.edge_md) irq_o = flt & ~prev;
        else                    irq_o = flt;
    end

    assign sel_oor = {1'b0, cfg_i.sel} >= (SEL_W+1)'(NUM_PADS);

    // R6: a single-edge pulse lasts one clock while configuration is unchanged.
    a_r6_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.edge_md && !cfg_i.both_md && irq_o) |=> (!irq_o || !$stable(cfg_i)));
    // R10: an unimplemented pad in plain level mode never asserts the output.
    a_r10_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oor && !cfg_i.edge_md && !cfg_i.both_md && !cfg_i.pol_low && cfg_i.filt == '0) |-> !irq_o);
endmodule

// File: rtl/gpio_irq_mux.sv
// Module: top level - synchronises pads and instantiates the register file and eight channels.
// Assumes NUM_PADS is between 1 and 256 (8-bit selectors).
module gpio_irq_mux
    import gim_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic                reg_we,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic [31:0]         reg_wmask,
    output logic [31:0]         reg_rdata,
    output logic [NUM_CH-1:0]   irq_o
);
    logic [NUM_PADS-1:0]  pads_s;
    ch_cfg_t [NUM_CH-1:0] cfg;

    gim_sync #(.W(NUM_PADS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(pads_s)
    );

    gim_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .wmask_i(reg_wmask), .rdata_o(reg_rdata), .cfg_o(cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        gim_channel #(.NUM_PADS(NUM_PADS)) u_ch (
            .clk(clk), .rst_n(rst_n), .pads_i(pads_s), .cfg_i(cfg[n]), .irq_o(irq_o[n])
        );
    end
endmodule

// File: tb/tb_gpio_irq_mux.sv
module tb_gpio_irq_mux;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad = '0;
    logic          we = 1'b0;
    logic [3:0]    addr = 4'h0;
    logic [31:0]   wdata = '0, wmask = '0, rdata;
    logic [7:0]    irq;
    int            total = 0, bad = 0;
    bit            finished = 1'b0;

    gpio_irq_mux #(.NUM_PADS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_wmask(wmask), .reg_rdata(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [31:0] m);
        addr = a; wdata = d; wmask = m; we = 1'b1;
        tick(1);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        addr = a; #1;
        chk(rdata == exp, req, rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk(4'h0, 0, "R1"); rd_chk(4'h4, 0, "R1");
        rd_chk(4'h8, 0, "R1"); rd_chk(4'hC, 0, "R1");
        chk(irq == 8'h00, "R1", irq, 8'h00);
        pad[0] = 1'b1; tick(2);
        chk(irq == 8'hFF, "R1", irq, 8'hFF);
        pad[0] = 1'b0; tick(2);
        chk(irq == 8'h00, "R1", irq, 8'h00);
    endtask

    task automatic t_map;
        // ch0=pad3, ch1=pad9, ch2=pad10, ch3=pad11
        wr(4'h4, 32'h0B0A0903, 32'hFFFFFFFF);
        rd_chk(4'h4, 32'h0B0A0903, "R2");
        wr(4'h0, 32'hFF000000, 32'hFF000000);
        rd_chk(4'h0, 32'h0, "R2");
        rd_chk(4'h6, 32'h0, "R2");
    endtask

    task automatic t_rmw;
        wr(4'h8, 32'hFFFF05FF, 32'h0000FF00);   // ch5 := pad5 only
        rd_chk(4'h8, 32'h00000500, "R3");
        wr(4'h8, 32'h00000000, 32'h00000000);
        rd_chk(4'h8, 32'h00000500, "R3");
        wr(4'h8, 32'h00000000, 32'h0000FF00);   // back to pad0
    endtask

    task automatic t_level;
        pad[3] = 1'b1; tick(1);
        chk(irq[0] == 1'b0, "R4", irq[0], 0);
        tick(1);
        chk(irq[0] == 1'b1, "R4", irq[0], 1);
        chk(irq[7:4] == 4'h0, "R11", irq[7:4], 0);
        wr(4'h0, 32'h00010000, 32'h00010000);
        chk(irq[0] == 1'b0, "R5", irq[0], 0);
        pad[3] = 1'b0; tick(2);
        chk(irq[0] == 1'b1, "R5", irq[0], 1);
        wr(4'h0, 32'h0, 32'h00010000);
    endtask

    task automatic t_edge;
        wr(4'h0, 32'h00000002, 32'h00000002);   // ch1 edge
        pad[9] = 1'b1; tick(2);
        chk(irq[1] == 1'b1, "R6", irq[1], 1);
        tick(1);
        chk(irq[1] == 1'b0, "R6", irq[1], 0);
        pad[9] = 1'b0; tick(2);
        chk(irq[1] == 1'b0, "R6", irq[1], 0);
        wr(4'h0, 32'h00020000, 32'h00020000);   // ch1 falling
        tick(2);
        pad[9] = 1'b1; tick(2);
        chk(irq[1] == 1'b0, "R7", irq[1], 0);
        pad[9] = 1'b0; tick(2);
        chk(irq[1] == 1'b1, "R7", irq[1], 1);
        tick(1);
        chk(irq[1] == 1'b0, "R7", irq[1], 0);
        wr(4'h0, 32'h00000200, 32'h00000200);   // ch1 both, edge+pol still set
        tick(2);
        pad[9] = 1'b1; tick(2);
        chk(irq[1] == 1'b1, "R8", irq[1], 1);
        tick(1);
        chk(irq[1] == 1'b0, "R8", irq[1], 0);
        pad[9] = 1'b0; tick(2);
        chk(irq[1] == 1'b1, "R8", irq[1], 1);
        tick(1);
        chk(irq[1] == 1'b0, "R8", irq[1], 0);
    endtask

    task automatic t_filter;
        wr(4'hC, 32'h00000100, 32'h00000F00);   // ch2 filter 1 -> 4 clocks
        pad[10] = 1'b1; tick(2);
        pad[10] = 1'b0; tick(6);
        chk(irq[2] == 1'b0, "R9", irq[2], 0);
        pad[10] = 1'b1; tick(5);
        chk(irq[2] == 1'b0, "R9", irq[2], 0);
        tick(1);
        chk(irq[2] == 1'b1, "R9", irq[2], 1);
        pad[10] = 1'b0;
    endtask

    task automatic t_oor;
        pad = '1;
        wr(4'h8, 32'h000000C8, 32'h000000FF);   // ch4 := 200
        tick(2);
        chk(irq[4] == 1'b0, "R10", irq[4], 0);
        chk(irq[5] == 1'b1, "R11", irq[5], 1);
        wr(4'h0, 32'h00100000, 32'h00100000);
        chk(irq[4] == 1'b1, "R10", irq[4], 1);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_map();
        t_rmw();
        t_level();
        t_edge();
        t_filter();
        t_oor();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule